// File: doc/BRIEF.md
# Fail-Stop Stable-Storage Write Checker

This block sits on the write path of one storage node inside a computer built to stop cleanly when up to K of its replicated processors fail. Each of the K+1 processors sends the node its own copy of every write: a sequence number, an address and a data word. The node holds the copies for the current sequence number until all of them have arrived. It then compares them. If every copy agrees, the word goes into local storage. If any copy differs, no write happens and a sticky failure flag is raised. The node only detects faults: it never picks a majority and never repairs a value.

The node also cross-checks itself against its peers. The other 2K storage nodes report the write they last received. When such a report differs from this node's own last committed write, this node regards stable storage as broken and halts. After it halts, it takes no more writes. Its stored words and its failure flag stay readable through the read port until reset.

A processor that never delivers its copy also stops the node. A timer starts when the first copy of a round arrives, and if the round is still incomplete when the timer runs out, this counts as a mismatch. Reads have one cycle of latency. A read is refused in the cycle where a commit takes place, so a read never sees a half-finished update.

Top module: `ss_commit_node`

## Requirements
- R1: A copy is captured only if its valid bit is high, its slot is empty and its sequence number equals the node's current round number. The round number starts at 0 and wraps modulo 2^SEQW. A copy with any other sequence number, or a second copy on a slot that is already filled, is ignored.
- R2: When all K+1 slots are filled with equal address and data, the node writes the data to that address at the next clock edge, advances the round number by one and empties every slot.
- R3: When the slots are all filled but any address or data differs, storage is left unchanged and `node_failed` goes high at the next clock edge.
- R4: Once `node_failed` is high, it stays high until reset. No copy is captured and no word is written while it is high.
- R5: If at least one slot is filled and the round is still incomplete TIMEOUT clock edges after the first capture, `node_failed` goes high at that edge and storage is unchanged.
- R6: A valid peer report with an address or data that differs from this node's last committed write sets `node_failed` at the next edge. A matching report has no effect. Reports that arrive before the first commit are ignored.
- R7: A read request is granted (`rd_grant` high) in every cycle except a commit cycle. A granted read returns `rd_valid` high together with the stored word one clock later. Reads keep working after a failure.
- R8: Reset clears `node_failed`, sets the round number to 0 and sets every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_valid | input | K+1 | One valid bit per processor copy |
| cp_seq | input | (K+1)*SEQW | Sequence number of each copy; copy i in bits [i*SEQW +: SEQW] |
| cp_addr | input | (K+1)*AW | Address of each copy; copy i in bits [i*AW +: AW] |
| cp_data | input | (K+1)*DW | Data of each copy; copy i in bits [i*DW +: DW] |
| pr_valid | input | 2K | One valid bit per peer storage node report |
| pr_addr | input | 2K*AW | Address reported by each peer |
| pr_data | input | 2K*DW | Data reported by each peer |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_grant | output | 1 | Read request accepted this cycle |
| rd_valid | output | 1 | Read data valid, one cycle after a grant |
| rd_data | output | DW | Word read from storage |
| node_failed | output | 1 | Sticky failure status |

## Verification
The assertions check, on every cycle, the properties that hold at all times. The failure flag stays high once set. No write happens while failed or while a read is granted. Each commit advances the round by exactly one. Every granted read is answered in the next cycle. An incomplete round never outlives the timeout window. A peer disagreement leads to failure. Only the bench's scenarios can show that committed words land at the right address with the right data, that stale or duplicate copies are dropped, that a mismatched round leaves storage untouched, and that reset returns the node to a blank state. They do this through reads against a reference memory.

// File: rtl/ss_commit_node.sv
module ss_commit_node #(
  parameter int K       = 1,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int SEQW    = 4,
  parameter int TIMEOUT = 16,
  localparam int NC     = K + 1,
  localparam int NP     = 2 * K
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC-1:0]     cp_valid,
  input  logic [NC*SEQW-1:0] cp_seq,
  input  logic [NC*AW-1:0]  cp_addr,
  input  logic [NC*DW-1:0]  cp_data,
  input  logic [NP-1:0]     pr_valid,
  input  logic [NP*AW-1:0]  pr_addr,
  input  logic [NP*DW-1:0]  pr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_grant,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              node_failed
);
  localparam int DEPTH = 1 << AW;
  localparam int TW    = $clog2(TIMEOUT + 1);

  logic [AW-1:0]   slot_addr [NC];
  logic [DW-1:0]   slot_data [NC];
  logic [NC-1:0]   got;
  logic [SEQW-1:0] seq_q;
  logic [TW-1:0]   tmr;
  logic            failed_q;
  logic [AW-1:0]   own_addr;
  logic [DW-1:0]   own_data;
  logic            own_vld;
  logic [DW-1:0]   mem [DEPTH];

  logic            all_got, same, mem_we, bad_round, tout, peer_bad, fail_now;
  logic [NC-1:0]   accept;

  assign all_got = &got;

  always_comb begin
    same = 1'b1;
    for (int i = 1; i < NC; i++)
      if (slot_addr[i] != slot_addr[0] || slot_data[i] != slot_data[0]) same = 1'b0;
  end

  always_comb begin
    peer_bad = 1'b0;
    for (int j = 0; j < NP; j++)
      if (pr_valid[j] && own_vld &&
          (pr_addr[j*AW +: AW] != own_addr || pr_data[j*DW +: DW] != own_data))
        peer_bad = 1'b1;
  end

  generate
    for (genvar g = 0; g < NC; g++) begin : g_acc
      assign accept[g] = ~failed_q & ~all_got & ~got[g] & cp_valid[g] &
                         (cp_seq[g*SEQW +: SEQW] == seq_q);
    end
  endgenerate

  assign mem_we    = all_got & same & ~failed_q;
  assign bad_round = all_got & ~same;
  assign tout      = (|got) & ~all_got & (tmr == TW'(TIMEOUT - 1));
  assign fail_now  = bad_round | tout | peer_bad;
  assign rd_grant  = rd_en & ~mem_we;
  assign node_failed = failed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got      <= '0;
      seq_q    <= '0;
      tmr      <= '0;
      failed_q <= 1'b0;
      own_vld  <= 1'b0;
      own_addr <= '0;
      own_data <= '0;
      for (int i = 0; i < NC; i++) begin
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end
    end else begin
      if (fail_now) failed_q <= 1'b1;
      if (all_got) begin
        got <= '0;
        tmr <= '0;
      end else begin
        for (int i = 0; i < NC; i++)
          if (accept[i]) begin
            got[i]       <= 1'b1;
            slot_addr[i] <= cp_addr[i*AW +: AW];
            slot_data[i] <= cp_data[i*DW +: DW];
          end
        if (got == '0 || failed_q) tmr <= '0;
        else                       tmr <= tmr + 1'b1;
      end
      if (mem_we) begin
        seq_q    <= seq_q + 1'b1;
        own_vld  <= 1'b1;
        own_addr <= slot_addr[0];
        own_data <= slot_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (mem_we) begin
      mem[slot_addr[0]] <= slot_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_grant;
      if (rd_grant) rd_data <= mem[rd_addr];
    end
  end
endmodule

module ss_commit_node_chk #(
  parameter int NC      = 2,
  parameter int SEQW    = 4,
  parameter int TIMEOUT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            node_failed,
  input logic            mem_we,
  input logic            peer_bad,
  input logic [NC-1:0]   got,
  input logic [SEQW-1:0] seq_q,
  input logic            rd_en,
  input logic            rd_grant,
  input logic            rd_valid
);
  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] run;
  logic partial;
  assign partial = (|got) & ~(&got) & ~node_failed;

  always_ff @(posedge clk) begin
    if (!rst_n)       run <= '0;
    else if (partial) run <= run + 1'b1;
    else              run <= '0;
  end

  assert_sticky_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    node_failed |=> node_failed);
  assert_no_write_failed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    node_failed |-> !mem_we);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> seq_q == $past(seq_q) + 1'b1);
  assert_seq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(seq_q));
  assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rd_grant);
  assert_read_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_grant) |=> rd_valid);
  assert_read_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_grant |=> !rd_valid);
  assert_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    partial |-> run < CW'(TIMEOUT));
  assert_peer_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peer_bad |=> node_failed);
endmodule

bind ss_commit_node ss_commit_node_chk #(.NC(NC), .SEQW(SEQW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .node_failed(node_failed), .mem_we(mem_we),
  .peer_bad(peer_bad), .got(got), .seq_q(seq_q), .rd_en(rd_en),
  .rd_grant(rd_grant), .rd_valid(rd_valid));

// File: tb/ss_commit_node_bench.sv
module ss_commit_node_bench;
  localparam int K = 1, AW = 4, DW = 8, SEQW = 4, TO = 16;
  localparam int NC = K + 1, NP = 2 * K;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] cp_valid = '0;
  logic [NC*SEQW-1:0] cp_seq = '0;
  logic [NC*AW-1:0] cp_addr = '0;
  logic [NC*DW-1:0] cp_data = '0;
  logic [NP-1:0] pr_valid = '0;
  logic [NP*AW-1:0] pr_addr = '0;
  logic [NP*DW-1:0] pr_data = '0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_grant, rd_valid, node_failed;
  logic [DW-1:0] rd_data;

  ss_commit_node #(.K(K), .AW(AW), .DW(DW), .SEQW(SEQW), .TIMEOUT(TO)) u_ss_commit_node (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [1 << AW];
  logic [SEQW-1:0] seq = '0;

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic put(input int i, input logic [SEQW-1:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cp_valid[i] = 1'b1;
    cp_seq[i*SEQW +: SEQW] = s;
    cp_addr[i*AW +: AW] = a;
    cp_data[i*DW +: DW] = d;
  endtask

  task automatic do_reset();
    rst_n = 0; cp_valid = '0; pr_valid = '0; rd_en = 0;
    tick(); tick(); rst_n = 1; tick();
    foreach (ref_mem[a]) ref_mem[a] = '0;
    seq = '0;
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a);
    rd_en = 1; rd_addr = a;
    tick(); rd_en = 0;
    check(req, rd_valid, 1);
    check(req, rd_data, exp_word(a));
  endtask

  task automatic round_ok(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap, input bit swap);
    int f = swap ? 1 : 0;
    put(f, seq, a, d);
    if (gap > 0) begin
      tick(); cp_valid = '0;
      repeat (gap - 1) tick();
    end
    put(1 - f, seq, a, d);
    tick(); cp_valid = '0;
    tick();
    ref_mem[a] = d; seq = seq + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    // R8: reset state
    check("R8 failed after reset", node_failed, 0);
    read_chk("R8 zero word", 4'h7);

    // R2: random agreeing rounds
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      round_ok(a, d, int'($urandom % 4), bit'($urandom % 2));
      if (n % 4 == 0) read_chk("R2 committed word", a);
    end
    for (int a = 0; a < 16; a++) read_chk("R2 memory sweep", AW'(a));
    check("R2 no failure on agreement", node_failed, 0);

    // R1: stale sequence and duplicate copy ignored
    put(0, seq + 1'b1, 4'h3, 8'hEE); tick(); cp_valid = '0;
    put(0, seq, 4'h3, 8'h5A); tick(); cp_valid = '0;
    put(0, seq, 4'h3, 8'hBB); tick(); cp_valid = '0;
    put(1, seq, 4'h3, 8'h5A); tick(); cp_valid = '0; tick();
    ref_mem[3] = 8'h5A; seq = seq + 1'b1;
    check("R1 stale/duplicate ignored", node_failed, 0);
    read_chk("R1 first copy kept", 4'h3);

    // R7: read refused in commit cycle
    put(0, seq, 4'h9, 8'hC3); put(1, seq, 4'h9, 8'hC3);
    tick(); cp_valid = '0;
    rd_en = 1; rd_addr = 4'h9; #1;
    check("R7 no grant in commit cycle", rd_grant, 0);
    tick();
    ref_mem[9] = 8'hC3; seq = seq + 1'b1;
    check("R7 no valid after refused read", rd_valid, 0);
    check("R7 grant after commit", rd_grant, 1);
    tick(); rd_en = 0;
    check("R7 one-cycle read valid", rd_valid, 1);
    check("R7 read returns whole new word", rd_data, 8'hC3);

    // R6: matching peer report has no effect
    pr_valid = 2'b01; pr_addr = {4'h0, 4'h9}; pr_data = {8'h0, 8'hC3};
    tick(); pr_valid = '0; tick();
    check("R6 matching peer no effect", node_failed, 0);

    // R3: data mismatch suppresses write and fails
    put(0, seq, 4'h9, 8'h11); put(1, seq, 4'h9, 8'h12);
    tick(); cp_valid = '0; tick();
    check("R3 mismatch sets failed", node_failed, 1);
    read_chk("R3 storage unchanged", 4'h9);

    // R4: sticky, no write after failure
    put(0, seq, 4'h2, 8'h77); put(1, seq, 4'h2, 8'h77);
    tick(); cp_valid = '0; tick(); tick();
    check("R4 stays failed", node_failed, 1);
    read_chk("R4 no write after failure", 4'h2);
    read_chk("R7 read after failure", 4'h3);

    // R8: reset clears status and storage
    do_reset();
    check("R8 reset clears failed", node_failed, 0);
    read_chk("R8 storage cleared", 4'h3);

    // R3: address mismatch
    put(0, seq, 4'h4, 8'h44); put(1, seq, 4'h5, 8'h44);
    tick(); cp_valid = '0; tick();
    check("R3 address mismatch fails", node_failed, 1);
    read_chk("R3 addr4 untouched", 4'h4);
    read_chk("R3 addr5 untouched", 4'h5);

    // R5: timeout
    do_reset();
    put(0, seq, 4'h6, 8'h66); tick(); cp_valid = '0;
    repeat (TO - 1) tick();
    check("R5 not failed before timeout", node_failed, 0);
    tick();
    check("R5 failed at timeout", node_failed, 1);
    put(1, seq, 4'h6, 8'h66); tick(); cp_valid = '0; tick();
    read_chk("R5 late copy not written", 4'h6);

    // R6: peer report before first commit ignored, then mismatch halts
    do_reset();
    pr_valid = 2'b10; pr_addr = {4'h1, 4'h0}; pr_data = {8'h99, 8'h0};
    tick(); pr_valid = '0;
    check("R6 peer before commit ignored", node_failed, 0);
    round_ok(4'hA, 8'hA5, 0, 0);
    pr_valid = 2'b10; pr_addr = {4'hA, 4'h0}; pr_data = {8'hA4, 8'h0};
    tick(); pr_valid = '0;
    check("R6 peer mismatch halts", node_failed, 1);
    read_chk("R6 committed word readable", 4'hA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule